// File: doc/BRIEF.md
# Dual-Bank Register File with Shared Stack Pointer

This block holds the general-purpose registers of a processor datapath in two banks, A and B. Registers 0 to 14 of each bank are private 32-bit words. Index 15 in either bank reaches one common stack-pointer register, so a value written through either bank can be read back through both. A register is addressed by a bank-select bit plus a 4-bit index.

The block has two combinational read ports and one synchronous write port. A read that targets the register being written in the same cycle returns the incoming data (write-first). A separate adjust strobe moves the stack pointer by a 32-bit step for push and pop. When a port write to index 15 lands in the same cycle as an adjust, the port write takes priority.

The block uses an asynchronous active-low reset that clears all 31 physical registers. Bank B gives no special treatment to pixel operations; at this level its registers are ordinary storage.

Top module: `dual_bank_regfile`

## Requirements
- R1: While reset is asserted, and after it is released, every register (both banks, indices 0 to 15) reads 0 until it is written.
- R2: A port write (`wr_en`=1) to bank b, index i in 0..14 stores `wr_data` at the rising clock edge, and that value then reads back from {b,i}.
- R3: Bank A (bank bit 0) and bank B (bank bit 1) are independent for indices 0..14: writing {A,i} leaves {B,i} unchanged, and the reverse also holds.
- R4: Index 15 ignores the bank bit. A write to {A,15} reads back from {B,15}, and the reverse also holds.
- R5: Write-first bypass. When `wr_en`=1 and a read port's address equals the write address in the same cycle, that port shows `wr_data` combinationally. For index 15 the bank bits of the two addresses may differ.
- R6: When `sp_adj_en`=1 and no port write targets index 15, the stack pointer becomes SP-`sp_step` (modulo 2^32) if `sp_adj_dir`=0 (push), or SP+`sp_step` if `sp_adj_dir`=1 (pop), at the next rising edge.
- R7: A port write to index 15 and an adjust in the same cycle leave the stack pointer equal to `wr_data`.
- R8: The two read ports decode their addresses independently and return different registers in the same cycle.
- R9: With `wr_en`=0 and `sp_adj_en`=0, no register changes, whatever `wr_data` and the write address are.
- R10: During a cycle that only adjusts the stack pointer, a read of index 15 returns the value from before the adjustment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write-port enable |
| wr_bank | input | 1 | Write bank: 0 = A, 1 = B |
| wr_idx | input | 4 | Write register index; 15 = stack pointer |
| wr_data | input | 32 | Write data |
| rd0_bank | input | 1 | Read port 0 bank select |
| rd0_idx | input | 4 | Read port 0 index |
| rd0_data | output | 32 | Read port 0 data (combinational) |
| rd1_bank | input | 1 | Read port 1 bank select |
| rd1_idx | input | 4 | Read port 1 index |
| rd1_data | output | 32 | Read port 1 data (combinational) |
| sp_adj_en | input | 1 | Stack-pointer adjust strobe |
| sp_adj_dir | input | 1 | 0 = push (subtract step), 1 = pop (add step) |
| sp_step | input | 32 | Adjust amount |

## Verification
A port write and a stack-pointer adjust can fall in the same cycle, and so can a port write and a read of the same register. The bench raises `sp_adj_en` together with a write to {B,15} and expects the stack pointer to hold exactly `wr_data` afterwards, with no trace of the step. It also presents a write and a matching read address in the same cycle, including a bank-A write to index 15 read through bank B. Before the clock edge, the read port must already show the new data.

// File: rtl/drf_pkg.sv
package drf_pkg;

  typedef enum logic {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } bank_e;

  typedef enum logic {
    SP_PUSH = 1'b0,
    SP_POP  = 1'b1
  } sp_dir_e;

endpackage

// File: rtl/drf_bank.sv
module drf_bank #(
  parameter int DATA_W   = 32,
  parameter int NUM_PRIV = 15,
  parameter int IDX_W    = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_PRIV-1:0][DATA_W-1:0]  regs_o
);

  logic [NUM_PRIV-1:0][DATA_W-1:0] regs_q;
  logic [NUM_PRIV-1:0][DATA_W-1:0] regs_d;
  logic [NUM_PRIV-1:0]             reg_ce;

  for (genvar g = 0; g < NUM_PRIV; g++) begin : g_reg
    always_comb begin
      reg_ce[g] = wr_en && (wr_idx == IDX_W'(g));
      regs_d[g] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (reg_ce[g]) begin
        regs_q[g] <= regs_d[g];
      end
    end
  end

  assign regs_o = regs_q;

endmodule

// File: rtl/drf_stack_ptr.sv
module drf_stack_ptr #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              adj_en,
  input  drf_pkg::sp_dir_e  adj_dir,
  input  logic [DATA_W-1:0] step,
  output logic [DATA_W-1:0] sp_o
);

  logic [DATA_W-1:0] sp_q;
  logic [DATA_W-1:0] sp_d;
  logic              sp_ce;

  always_comb begin
    sp_ce = wr_en || adj_en;
    if (wr_en) begin
      sp_d = wr_data;
    end else if (adj_dir == drf_pkg::SP_POP) begin
      sp_d = sp_q + step;
    end else begin
      sp_d = sp_q - step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
    end else if (sp_ce) begin
      sp_q <= sp_d;
    end
  end

  assign sp_o = sp_q;

endmodule

// File: rtl/drf_read_port.sv
module drf_read_port #(
  parameter int DATA_W   = 32,
  parameter int NUM_PRIV = 15,
  parameter int IDX_W    = 4
) (
  input  logic                             rd_bank,
  input  logic [IDX_W-1:0]                 rd_idx,
  input  logic [NUM_PRIV-1:0][DATA_W-1:0]  bank_a,
  input  logic [NUM_PRIV-1:0][DATA_W-1:0]  bank_b,
  input  logic [DATA_W-1:0]                sp,
  input  logic                             wr_en,
  input  logic                             wr_bank,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [DATA_W-1:0]                rd_data
);

  localparam logic [IDX_W-1:0] SP_IDX = IDX_W'(NUM_PRIV);

  logic              rd_is_sp;
  logic              wr_is_sp;
  logic              hit;
  logic [DATA_W-1:0] stored;

  always_comb begin
    rd_is_sp = (rd_idx == SP_IDX);
    wr_is_sp = (wr_idx == SP_IDX);
    hit      = wr_en && (rd_idx == wr_idx) && (rd_is_sp || (rd_bank == wr_bank));
    stored   = '0;
    if (rd_is_sp) begin
      stored = sp;
    end else if (rd_idx < SP_IDX) begin
      stored = (rd_bank == drf_pkg::BANK_B) ? bank_b[rd_idx] : bank_a[rd_idx];
    end
    rd_data = hit ? wr_data : stored;
  end

  logic unused_wr_is_sp;
  assign unused_wr_is_sp = wr_is_sp;

endmodule

// File: rtl/dual_bank_regfile.sv
module dual_bank_regfile #(
  parameter int DATA_W   = 32,
  parameter int NUM_PRIV = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_bank,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd0_bank,
  input  logic [3:0]        rd0_idx,
  output logic [DATA_W-1:0] rd0_data,
  input  logic              rd1_bank,
  input  logic [3:0]        rd1_idx,
  output logic [DATA_W-1:0] rd1_data,
  input  logic              sp_adj_en,
  input  logic              sp_adj_dir,
  input  logic [DATA_W-1:0] sp_step
);

  localparam int IDX_W = 4;
  localparam logic [IDX_W-1:0] SP_IDX = IDX_W'(NUM_PRIV);
  localparam int NUM_RD = 2;

  logic [NUM_PRIV-1:0][DATA_W-1:0] regs_a;
  logic [NUM_PRIV-1:0][DATA_W-1:0] regs_b;
  logic [DATA_W-1:0]               sp_q;
  logic                            wr_sp;
  logic                            wr_a;
  logic                            wr_b;
  drf_pkg::sp_dir_e                adj_dir;

  always_comb begin
    wr_sp   = wr_en && (wr_idx == SP_IDX);
    wr_a    = wr_en && (wr_idx < SP_IDX) && (wr_bank == drf_pkg::BANK_A);
    wr_b    = wr_en && (wr_idx < SP_IDX) && (wr_bank == drf_pkg::BANK_B);
    adj_dir = drf_pkg::sp_dir_e'(sp_adj_dir);
  end

  drf_bank #(.DATA_W(DATA_W), .NUM_PRIV(NUM_PRIV), .IDX_W(IDX_W)) u_bank_a (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_a), .wr_idx(wr_idx),
    .wr_data(wr_data), .regs_o(regs_a)
  );

  drf_bank #(.DATA_W(DATA_W), .NUM_PRIV(NUM_PRIV), .IDX_W(IDX_W)) u_bank_b (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_b), .wr_idx(wr_idx),
    .wr_data(wr_data), .regs_o(regs_b)
  );

  drf_stack_ptr #(.DATA_W(DATA_W)) u_sp (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_sp), .wr_data(wr_data),
    .adj_en(sp_adj_en), .adj_dir(adj_dir), .step(sp_step), .sp_o(sp_q)
  );

  logic [NUM_RD-1:0]             rd_bank_v;
  logic [NUM_RD-1:0][IDX_W-1:0]  rd_idx_v;
  logic [NUM_RD-1:0][DATA_W-1:0] rd_data_v;

  assign rd_bank_v = {rd1_bank, rd0_bank};
  assign rd_idx_v  = {rd1_idx, rd0_idx};

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    drf_read_port #(.DATA_W(DATA_W), .NUM_PRIV(NUM_PRIV), .IDX_W(IDX_W)) u_port (
      .rd_bank(rd_bank_v[p]), .rd_idx(rd_idx_v[p]),
      .bank_a(regs_a), .bank_b(regs_b), .sp(sp_q),
      .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_data(rd_data_v[p])
    );
  end

  assign rd0_data = rd_data_v[0];
  assign rd1_data = rd_data_v[1];

endmodule

// File: rtl/dual_bank_regfile_chk.sv
module dual_bank_regfile_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_bank,
  input logic [3:0]        wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd0_bank,
  input logic [3:0]        rd0_idx,
  input logic [DATA_W-1:0] rd0_data,
  input logic [3:0]        rd1_idx,
  input logic [DATA_W-1:0] rd1_data,
  input logic              sp_adj_en,
  input logic              sp_adj_dir,
  input logic [DATA_W-1:0] sp_step,
  input logic [DATA_W-1:0] sp_q
);

  // R6
  sp_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_adj_en && !sp_adj_dir && !(wr_en && wr_idx == 4'd15))
      |=> sp_q == $past(sp_q) - $past(sp_step));

  // R6
  sp_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_adj_en && sp_adj_dir && !(wr_en && wr_idx == 4'd15))
      |=> sp_q == $past(sp_q) + $past(sp_step));

  // R7
  wr_over_adj_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 4'd15) |=> sp_q == $past(wr_data));

  // R5
  bypass_rd0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == rd0_idx && (wr_idx == 4'd15 || wr_bank == rd0_bank))
      |-> rd0_data == wr_data);

  // R4
  alias_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_idx == 4'd15 && rd1_idx == 4'd15) |-> rd0_data == rd1_data);

  // R9
  sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !sp_adj_en) |=> $stable(sp_q));

endmodule

bind dual_bank_regfile dual_bank_regfile_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx),
  .wr_data(wr_data), .rd0_bank(rd0_bank), .rd0_idx(rd0_idx), .rd0_data(rd0_data),
  .rd1_idx(rd1_idx), .rd1_data(rd1_data), .sp_adj_en(sp_adj_en),
  .sp_adj_dir(sp_adj_dir), .sp_step(sp_step), .sp_q(sp_q)
);

// File: tb/dual_bank_regfile_test.sv
`timescale 1ns/1ps
module dual_bank_regfile_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_bank = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        rd0_bank = 1'b0, rd1_bank = 1'b0;
  logic [3:0]  rd0_idx = '0, rd1_idx = '0;
  logic [31:0] rd0_data, rd1_data;
  logic        sp_adj_en = 1'b0, sp_adj_dir = 1'b0;
  logic [31:0] sp_step = '0;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [31:0] exp_a [15];
  logic [31:0] exp_b [15];
  logic [31:0] exp_sp;

  always #10 clk = ~clk;

  dual_bank_regfile uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd0_bank(rd0_bank), .rd0_idx(rd0_idx), .rd0_data(rd0_data),
    .rd1_bank(rd1_bank), .rd1_idx(rd1_idx), .rd1_data(rd1_data),
    .sp_adj_en(sp_adj_en), .sp_adj_dir(sp_adj_dir), .sp_step(sp_step)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic b, input logic [3:0] i);
    if (i == 4'd15) return exp_sp;
    return b ? exp_b[i] : exp_a[i];
  endfunction

  task automatic read0(input logic b, input logic [3:0] i, output logic [31:0] d);
    rd0_bank = b; rd0_idx = i; #1; d = rd0_data;
  endtask

  task automatic write(input logic b, input logic [3:0] i, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_bank = b; wr_idx = i; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (i == 4'd15) exp_sp = d; else if (b) exp_b[i] = d; else exp_a[i] = d;
  endtask

  task automatic check_all(input string req);
    logic [31:0] d;
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < 16; i++) begin
        read0(b[0], i[3:0], d);
        check(req, d, model(b[0], i[3:0]));
      end
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    read0(1'b1, 4'd7, d);
    check("R1 during reset", d, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    check_all("R1");
  endtask

  task automatic t_private;
    for (int i = 0; i < 15; i++) write(1'b0, i[3:0], 32'hA000_0000 | i);
    for (int i = 0; i < 15; i++) write(1'b1, i[3:0], 32'hB000_0000 | (i << 4));
    check_all("R2");
    write(1'b0, 4'd5, 32'hDEAD_0005);
    check_all("R3 A write leaves B");
    write(1'b1, 4'd14, 32'hBEEF_000E);
    check_all("R3 B write leaves A");
  endtask

  task automatic t_alias;
    logic [31:0] d;
    write(1'b0, 4'd15, 32'h0000_1000);
    read0(1'b1, 4'd15, d);
    check("R4 A15->B15", d, 32'h0000_1000);
    write(1'b1, 4'd15, 32'h0000_2000);
    read0(1'b0, 4'd15, d);
    check("R4 B15->A15", d, 32'h0000_2000);
  endtask

  task automatic t_bypass;
    @(negedge clk);
    wr_en = 1'b1; wr_bank = 1'b0; wr_idx = 4'd3; wr_data = 32'h1234_5678;
    rd0_bank = 1'b0; rd0_idx = 4'd3; rd1_bank = 1'b1; rd1_idx = 4'd3; #1;
    check("R5 same reg bypass", rd0_data, 32'h1234_5678);
    check("R5 other bank no bypass", rd1_data, exp_b[3]);
    @(negedge clk);
    exp_a[3] = 32'h1234_5678;
    wr_idx = 4'd15; wr_data = 32'h0000_3000; rd0_bank = 1'b1; rd0_idx = 4'd15; #1;
    check("R5 SP bypass across banks", rd0_data, 32'h0000_3000);
    @(negedge clk);
    wr_en = 1'b0; exp_sp = 32'h0000_3000;
    check_all("R5 after");
  endtask

  task automatic t_dual_read;
    @(negedge clk);
    rd0_bank = 1'b0; rd0_idx = 4'd9; rd1_bank = 1'b1; rd1_idx = 4'd9; #1;
    check("R8 port0", rd0_data, exp_a[9]);
    check("R8 port1", rd1_data, exp_b[9]);
    rd0_idx = 4'd15; rd1_idx = 4'd0; #1;
    check("R8 port0 sp", rd0_data, exp_sp);
    check("R8 port1 B0", rd1_data, exp_b[0]);
  endtask

  task automatic t_no_write;
    @(negedge clk);
    wr_en = 1'b0; wr_bank = 1'b1; wr_idx = 4'd2; wr_data = 32'hFFFF_FFFF;
    @(negedge clk);
    wr_idx = 4'd15;
    @(negedge clk);
    check_all("R9");
  endtask

  task automatic t_sp_adj;
    logic [31:0] d;
    write(1'b0, 4'd15, 32'h0000_0010);
    @(negedge clk);
    sp_adj_en = 1'b1; sp_adj_dir = 1'b0; sp_step = 32'd8;
    read0(1'b1, 4'd15, d);
    check("R10 old SP during push", d, 32'h0000_0010);
    @(negedge clk);
    sp_adj_en = 1'b0;
    read0(1'b0, 4'd15, d);
    check("R6 push", d, 32'h0000_0008);
    @(negedge clk);
    sp_adj_en = 1'b1; sp_adj_dir = 1'b1; sp_step = 32'd4;
    @(negedge clk);
    sp_adj_en = 1'b0;
    read0(1'b1, 4'd15, d);
    check("R6 pop", d, 32'h0000_000C);
    @(negedge clk);
    sp_adj_en = 1'b1; sp_adj_dir = 1'b0; sp_step = 32'h10;
    @(negedge clk);
    sp_adj_en = 1'b0;
    read0(1'b0, 4'd15, d);
    check("R6 push wraps", d, 32'hFFFF_FFFC);
    exp_sp = 32'hFFFF_FFFC;
    check_all("R6 banks untouched");
  endtask

  task automatic t_collision;
    logic [31:0] d;
    @(negedge clk);
    sp_adj_en = 1'b1; sp_adj_dir = 1'b1; sp_step = 32'd100;
    wr_en = 1'b1; wr_bank = 1'b1; wr_idx = 4'd15; wr_data = 32'h0000_8000;
    @(negedge clk);
    sp_adj_en = 1'b0; wr_en = 1'b0;
    read0(1'b0, 4'd15, d);
    check("R7 write wins", d, 32'h0000_8000);
    exp_sp = 32'h0000_8000;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 15; i++) begin exp_a[i] = '0; exp_b[i] = '0; end
    exp_sp = '0;
    repeat (3) @(negedge clk);
    t_reset;
    t_private;
    t_alias;
    t_bypass;
    t_dual_read;
    t_no_write;
    t_sp_adj;
    t_collision;
    finish_run;
  end

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run;
  end

endmodule